// File: doc/BRIEF.md
# Multithreaded Fetch Thread Picker

This block decides, once per clock, which hardware thread of a multithreaded fetch stage gets to use the fetch path. Each thread supplies an activity bit and a small fetch-state code. The block keeps an ordered list of thread IDs. In round-robin mode it grants the first eligible thread in that list. It then moves the winner to the tail, which gives fairness among the threads that are actually able to fetch.

A mode input chooses between round-robin arbitration and a single-thread mode, in which thread 0 always wins. A drain input suppresses every grant while the pipeline is being emptied. The grant is registered: inputs sampled at one rising edge show up as `grant_valid` and `grant_tid` right after that edge.

Top module: `fetch_thread_picker`

## Requirements
- R1: After reset, `grant_valid` is 0 and the priority list holds the thread IDs in ascending order (0 first).
- R2: A thread is eligible only when its `thread_active` bit is 1 and its 3-bit state code is 0 (running), 5 (cache access complete) or 6 (idle). The codes 1, 2, 3, 4 and 7 are never eligible.
- R3: In round-robin mode (`rr_mode`=1) with no drain, the grant after a rising edge names the first eligible thread in the priority list, with `grant_valid`=1.
- R4: After a round-robin grant, the winner leaves its position and goes to the tail of the list. The entries behind it each move one place forward.
- R5: In round-robin mode with no eligible thread, `grant_valid` is 0 and the list is left unchanged.
- R6: In single-thread mode (`rr_mode`=0) with no drain, the grant is thread 0 with `grant_valid`=1 whatever the thread states are, and the list is left unchanged.
- R7: While `drain_req` is 1, `grant_valid` is 0 in either mode and the list is left unchanged.
- R8: The priority list changes only in a cycle that makes a round-robin grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode | input | 1 | 1 = round-robin arbitration, 0 = single-thread mode |
| drain_req | input | 1 | Drain pending; blocks all grants |
| thread_active | input | NUM_THREADS | Per-thread activity bit |
| thread_state | input | NUM_THREADS*3 | Per-thread fetch state, thread t in bits [3t+2:3t] |
| grant_valid | output | 1 | A thread is granted this cycle |
| grant_tid | output | TID_W | Granted thread ID |

## Verification
On every cycle, the assertions check four things: a drain always yields no grant; single-thread mode always grants thread 0; round-robin with an empty eligible set grants nothing; and the priority list stays a permutation that holds still when no grant is made. Several behaviours can only be shown by the bench's scenarios, which track the list in a model and compare every granted ID against it. These are the order in which grants rotate among eligible threads, the move of each winner to the tail, the exact state codes that qualify, and the fact that a suppressed cycle leaves the rotation where it was.

// File: rtl/fetch_pick_pkg.sv
package fetch_pick_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    FS_RUN         = 3'd0,
    FS_SQUASH      = 3'd1,
    FS_STALLED     = 3'd2,
    FS_WAIT_FILL   = 3'd3,
    FS_WAIT_RESEND = 3'd4,
    FS_FILL_DONE   = 3'd5,
    FS_IDLE        = 3'd6,
    FS_SPARE       = 3'd7
  } fetch_state_e;

  function automatic logic state_can_fetch(logic [STATE_W-1:0] s);
    return (s == FS_RUN) || (s == FS_FILL_DONE) || (s == FS_IDLE);
  endfunction
endpackage

// File: rtl/fp_eligibility.sv
module fp_eligibility
  import fetch_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0]         active,
  input  logic [NUM_THREADS*STATE_W-1:0] state,
  output logic [NUM_THREADS-1:0]         elig
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign elig[t] = active[t] && state_can_fetch(state[t*STATE_W +: STATE_W]);
  end
endmodule

// File: rtl/fp_priority_order.sv
module fp_priority_order #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] elig,
  input  logic                   advance,
  output logic                   hit,
  output logic [TID_W-1:0]       hit_tid
);
  logic [TID_W-1:0] order_q [NUM_THREADS];
  logic [TID_W-1:0] order_d [NUM_THREADS];
  logic [TID_W-1:0] pos;
  logic [NUM_THREADS*TID_W-1:0] order_flat;
  logic [NUM_THREADS-1:0] seen;

  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (!hit && elig[order_q[i]]) begin
        hit = 1'b1;
        pos = TID_W'(i);
      end
    end
    hit_tid = order_q[pos];
  end

  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) order_d[i] = order_q[i];
    if (advance && hit) begin
      for (int i = 0; i < NUM_THREADS - 1; i++) begin
        if (TID_W'(i) >= pos) order_d[i] = order_q[i+1];
      end
      order_d[NUM_THREADS-1] = order_q[pos];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= TID_W'(i);
    end else begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= order_d[i];
    end
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      order_flat[i*TID_W +: TID_W] = order_q[i];
      seen[order_q[i]] = 1'b1;
    end
  end

  // R4: the list always holds every thread exactly once
  assert_order_perm_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(seen) == NUM_THREADS);

  // R8: no grant in round-robin terms means the list holds still
  assert_order_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(advance && hit) |=> $stable(order_flat));
endmodule

// File: rtl/fetch_thread_picker.sv
module fetch_thread_picker
  import fetch_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rr_mode,
  input  logic                           drain_req,
  input  logic [NUM_THREADS-1:0]         thread_active,
  input  logic [NUM_THREADS*STATE_W-1:0] thread_state,
  output logic                           grant_valid,
  output logic [TID_W-1:0]               grant_tid
);
  logic [NUM_THREADS-1:0] elig;
  logic                   hit;
  logic [TID_W-1:0]       hit_tid;
  logic                   advance;

  fp_eligibility #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .active (thread_active),
    .state  (thread_state),
    .elig   (elig)
  );

  assign advance = rr_mode && !drain_req;

  fp_priority_order #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_order (
    .clk     (clk),
    .rst     (rst),
    .elig    (elig),
    .advance (advance),
    .hit     (hit),
    .hit_tid (hit_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_tid   <= '0;
    end else if (drain_req) begin
      grant_valid <= 1'b0;
      grant_tid   <= '0;
    end else if (!rr_mode) begin
      grant_valid <= 1'b1;
      grant_tid   <= '0;
    end else begin
      grant_valid <= hit;
      grant_tid   <= hit ? hit_tid : '0;
    end
  end

  assert_drain_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    drain_req |=> !grant_valid);

  assert_single_thread0_R6: assert property (@(posedge clk) disable iff (rst)
    (!rr_mode && !drain_req) |=> (grant_valid && grant_tid == '0));

  assert_none_eligible_R5: assert property (@(posedge clk) disable iff (rst)
    (rr_mode && elig == '0) |=> !grant_valid);
endmodule

// File: tb/fetch_thread_picker_bench.sv
module fetch_thread_picker_bench;
  localparam int N = 4;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst;
  logic rr_mode, drain_req;
  logic [N-1:0] thread_active;
  logic [N*3-1:0] thread_state;
  logic grant_valid;
  logic [TW-1:0] grant_tid;

  int checks = 0;
  int errors = 0;
  int ord [N];
  logic pend = 1'b0;
  logic exp_v;
  int exp_t;
  string exp_tag;

  always #2 clk = ~clk;

  fetch_thread_picker #(.NUM_THREADS(N)) u_fetch_thread_picker (
    .clk(clk), .rst(rst), .rr_mode(rr_mode), .drain_req(drain_req),
    .thread_active(thread_active), .thread_state(thread_state),
    .grant_valid(grant_valid), .grant_tid(grant_tid)
  );

  function automatic bit can_go(bit act, logic [2:0] s);
    return act && (s == 3'd0 || s == 3'd5 || s == 3'd6);
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      chk({exp_tag, " valid"}, int'(grant_valid), int'(exp_v));
      if (exp_v) chk({exp_tag, " tid"}, int'(grant_tid), exp_t);
    end
  endtask

  // drive one cycle of inputs, after checking the previous cycle's grant
  task automatic step(bit rr, bit dr, logic [N-1:0] act, logic [N*3-1:0] st, string tag);
    int pos;
    int w;
    @(negedge clk);
    check_pending();
    rr_mode = rr; drain_req = dr; thread_active = act; thread_state = st;
    pos = -1;
    for (int i = 0; i < N; i++)
      if (pos < 0 && can_go(act[ord[i]], st[ord[i]*3 +: 3])) pos = i;
    if (dr) begin
      exp_v = 0; exp_t = 0; exp_tag = (tag == "") ? "R7" : tag;
    end else if (!rr) begin
      exp_v = 1; exp_t = 0; exp_tag = (tag == "") ? "R6" : tag;
    end else if (pos < 0) begin
      exp_v = 0; exp_t = 0; exp_tag = (tag == "") ? "R5" : tag;
    end else begin
      exp_v = 1; exp_t = ord[pos]; exp_tag = (tag == "") ? "R3" : tag;
      w = ord[pos];
      for (int i = pos; i < N - 1; i++) ord[i] = ord[i+1];
      ord[N-1] = w;
    end
    pend = 1'b1;
  endtask

  function automatic logic [N*3-1:0] all_state(logic [2:0] s);
    logic [N*3-1:0] v;
    for (int i = 0; i < N; i++) v[i*3 +: 3] = s;
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) ord[i] = i;
    rst = 1'b1; rr_mode = 1'b1; drain_req = 1'b0;
    thread_active = '0; thread_state = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", int'(grant_valid), 0);
    rst = 1'b0;

    // R1/R4: ascending start, then full rotation among all eligible
    for (int k = 0; k < 6; k++) step(1, 0, '1, all_state(3'd0), "R4 rotate");
    // R2: each non-fetching code blocks, qualifying codes pass
    step(1, 0, '1, all_state(3'd1), "R2 squash");
    step(1, 0, '1, all_state(3'd3), "R2 waitfill");
    step(1, 0, '1, all_state(3'd7), "R2 spare");
    step(1, 0, '1, all_state(3'd5), "R2 filldone");
    step(1, 0, '1, all_state(3'd6), "R2 idle");
    step(1, 0, 4'b0000, all_state(3'd0), "R2 inactive");
    // R5/R8: empty set, then rotation continues where it left off
    step(1, 0, '1, all_state(3'd2), "R5 none");
    step(1, 0, '1, all_state(3'd0), "R8 after none");
    // R7: drain in both modes, then rotation continues
    step(1, 1, '1, all_state(3'd0), "R7 drain rr");
    step(0, 1, '1, all_state(3'd0), "R7 drain single");
    step(1, 0, '1, all_state(3'd0), "R8 after drain");
    // R6: single mode with thread 0 not eligible, then rotation resumes
    step(0, 0, 4'b0000, all_state(3'd4), "R6 single");
    step(1, 0, '1, all_state(3'd0), "R8 after single");
    // R4: winner from the middle of the list
    step(1, 0, 4'b0100, all_state(3'd0), "R4 middle");
    step(1, 0, '1, all_state(3'd0), "R4 after middle");

    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] a;
      logic [N*3-1:0] s;
      bit rr, dr;
      a = N'($urandom);
      s = (N*3)'($urandom);
      rr = ($urandom % 8) != 0;
      dr = ($urandom % 8) == 0;
      step(rr, dr, a, s, "");
    end
    @(negedge clk);
    check_pending();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule